// File: doc/BRIEF.md
# Bit-Serial Packet Transmitter

This block sends one packet at a time over a single serial data line that travels with two active-low strobes: a frame strobe that brackets the packet and a valid strobe that qualifies payload bits. A host first fills a small byte buffer through a plain write port. It then presents a destination port number and a byte count and pulses `start`. The block serialises the packet in three phases. The destination address goes first, then a fixed pad, then the payload bytes. It then returns to idle and raises a one-cycle completion pulse.

The far end pushes back through an active-low busy input. Address and pad bits go out regardless of it. During the payload, a cycle in which the far end signals busy shows the current bit with the valid strobe inactive, and the bit pointer does not move. The packet is stretched but never abandoned. The frame strobe is released in the very cycle in which the last payload bit is accepted. After reset the block refuses to start for a fixed warm-up interval.

Top module: `bitser_tx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, after that edge `lane_frame_n` and `lane_valid_n` are 1, `lane_d` is 0 and `pkt_done` is 0.
- R2: A `start` sampled at any of the first 15 rising edges after `rst_n` goes high is ignored. A `start` at the 16th such edge is accepted.
- R3: After an accepted `start`, `lane_frame_n` is 0 for 4 cycles. `lane_d` carries `dest` bit 0, then bit 1, bit 2 and bit 3 (least significant first), whatever `sink_busy_n` is. `lane_valid_n` stays 1 throughout these cycles.
- R4: The 4 address cycles are followed by exactly 5 pad cycles with `lane_d` = 1, `lane_valid_n` = 1 and `lane_frame_n` = 0.
- R5: The payload holds `len_m1`+1 bytes (`len_m1` = 0 means 1 byte, 15 means 16), taken from buffer entries 0, 1, 2 … as written through `wr_en`/`wr_idx`/`wr_data`. Each byte is sent least significant bit first. `lane_valid_n` is 0 exactly in payload cycles where `sink_busy_n` is 1, and every such cycle accepts one bit.
- R6: In a payload cycle with `sink_busy_n` = 0, `lane_valid_n` is 1. `lane_d` shows the pending bit, and the same bit is presented again in the next cycle.
- R7: `lane_frame_n` stays 0 through the packet and rises in the cycle in which the final payload bit is presented with `sink_busy_n` = 1.
- R8: The cycle after the final bit is accepted is a gap cycle with `lane_frame_n` = 1, `lane_valid_n` = 1 and `lane_d` = 0. `pkt_done` is 1 for exactly the following cycle.
- R9: A `start` while a packet is in progress, including the gap cycle, is ignored. `dest` and `len_m1` are captured only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 4 | Buffer entry written |
| wr_data | input | 8 | Byte written into the buffer |
| start | input | 1 | Request to send one packet |
| dest | input | 4 | Destination port number, captured on start |
| len_m1 | input | 4 | Payload byte count minus one, captured on start |
| sink_busy_n | input | 1 | Far end ready when 1, busy when 0 |
| lane_d | output | 1 | Serial data line |
| lane_frame_n | output | 1 | Frame strobe, active low |
| lane_valid_n | output | 1 | Payload valid strobe, active low |
| pkt_done | output | 1 | One-cycle pulse after a packet ends |

## Verification
The properties assume the host holds `rst_n` low for at least one edge before use and keeps `sink_busy_n` stable around each rising edge, because that input feeds the strobes combinationally. They also assume the host leaves the buffer unwritten while a packet is running. The stimulus drives every input on the falling edge and reloads the buffer only between packets. It uses `start` and `sink_busy_n` as the only inputs that change mid-packet: busy is toggled through the address, pad and payload phases in several patterns, and stray starts are pushed into the pad and gap cycles.

// File: rtl/bitser_tx_pkg.sv
package bitser_tx_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_PAD  = 3'd2,
      PH_PAY  = 3'd3,
      PH_GAP  = 3'd4
   } phase_e;
endpackage

// File: rtl/bitser_warmup.sv
module bitser_warmup #(
   parameter int WARMUP = 15
) (
   input  logic clk,
   input  logic rst_n,
   output logic go_ok
);
   generate
      if (WARMUP == 0) begin : g_none
         assign go_ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(WARMUP + 1);
         localparam logic [CW-1:0] LIMIT = CW'(WARMUP);
         logic [CW-1:0] wcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               wcnt <= '0;
            else if (wcnt != LIMIT)
               wcnt <= wcnt + CW'(1);
         end
         assign go_ok = (wcnt == LIMIT);

         // R2: once permission is granted it is kept until reset
         p_warm_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            go_ok |=> go_ok);
      end
   endgenerate
endmodule

// File: rtl/bitser_buf.sv
module bitser_buf #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [BYTE_W-1:0]        wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [BYTE_W-1:0]        rd_byte
);
   localparam int IW = $clog2(DEPTH);
   logic [BYTE_W-1:0] mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(e))
               mem[e] <= wr_data;
         end
      end
   endgenerate

   assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/bitser_seq.sv
module bitser_seq
   import bitser_tx_pkg::*;
#(
   parameter int ADDR_BITS  = 4,
   parameter int BYTE_W     = 8,
   parameter int MAX_BYTES  = 16,
   parameter int PAD_CYCLES = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         go_ok,
   input  logic [ADDR_BITS-1:0]         dest_in,
   input  logic [$clog2(MAX_BYTES)-1:0] len_in,
   input  logic                         sink_busy_n,
   output phase_e                       ph,
   output logic                         addr_bit,
   output logic [$clog2(MAX_BYTES)-1:0] rd_idx,
   output logic [$clog2(BYTE_W)-1:0]    bit_sel,
   output logic                         last_bit,
   output logic                         done
);
   localparam int LEN_W  = $clog2(MAX_BYTES);
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int POS_W  = LEN_W + BIT_W;
   localparam int AIDX_W = $clog2(ADDR_BITS);
   localparam int PH_MAX = (ADDR_BITS > PAD_CYCLES) ? ADDR_BITS : PAD_CYCLES;
   localparam int CNT_W  = $clog2(PH_MAX + 1);
   localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_BITS - 1);
   localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PAD_CYCLES - 1);

   logic [CNT_W-1:0]     cnt;
   logic [POS_W-1:0]     pos;
   logic [ADDR_BITS-1:0] dest_q;
   logic [LEN_W-1:0]     lm1_q;
   logic                 take;

   assign take     = start && go_ok && (ph == PH_IDLE);
   assign last_bit = (pos == {lm1_q, {BIT_W{1'b1}}});
   assign rd_idx   = pos[POS_W-1:BIT_W];
   assign bit_sel  = pos[BIT_W-1:0];
   assign addr_bit = dest_q[cnt[AIDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         pos    <= '0;
         dest_q <= '0;
         lm1_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph)
            PH_IDLE: if (take) begin
               ph     <= PH_ADDR;
               cnt    <= '0;
               pos    <= '0;
               dest_q <= dest_in;
               lm1_q  <= len_in;
            end
            PH_ADDR: begin
               if (cnt == A_LAST) begin
                  ph  <= PH_PAD;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_PAD: begin
               if (cnt == P_LAST) begin
                  ph  <= PH_PAY;
                  pos <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_PAY: if (sink_busy_n) begin
               if (last_bit) ph <= PH_GAP;
               else          pos <= pos + POS_W'(1);
            end
            PH_GAP: begin
               ph   <= PH_IDLE;
               done <= 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R6: backpressure freezes the bit pointer inside the payload
   p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAY && !sink_busy_n) |=> (ph == PH_PAY && $stable(pos)));
   // R9: the address phase is entered only from idle
   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && ph != PH_ADDR) |=> (ph != PH_ADDR));
   // R9: captured destination is frozen once a packet is under way
   p_dest_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE) |=> $stable(dest_q));
   // R8: completion is a single-cycle pulse following the gap
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ph) == PH_GAP));
   // R2: no packet leaves idle before warm-up ends
   p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_ok && ph == PH_IDLE) |=> (ph == PH_IDLE));
endmodule

// File: rtl/bitser_lane.sv
module bitser_lane
   import bitser_tx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph,
   input  logic   addr_bit,
   input  logic   pay_bit,
   input  logic   last_bit,
   input  logic   sink_busy_n,
   output logic   lane_d,
   output logic   lane_frame_n,
   output logic   lane_valid_n
);
   always_comb begin
      lane_d       = 1'b0;
      lane_frame_n = 1'b1;
      lane_valid_n = 1'b1;
      case (ph)
         PH_ADDR: begin
            lane_d       = addr_bit;
            lane_frame_n = 1'b0;
         end
         PH_PAD: begin
            lane_d       = 1'b1;
            lane_frame_n = 1'b0;
         end
         PH_PAY: begin
            lane_d       = pay_bit;
            lane_valid_n = ~sink_busy_n;
            lane_frame_n = last_bit & sink_busy_n;
         end
         default: ;
      endcase
   end

   // R3: address cycles hold the frame low and never flag valid data
   p_addr_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_ADDR) |-> (lane_valid_n && !lane_frame_n));
   // R4: pad cycles drive a high line with valid inactive
   p_pad_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAD) |-> (lane_d && lane_valid_n && !lane_frame_n));
   // R7: a released frame during payload is always followed by the gap
   p_frame_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAY && lane_frame_n) |=> (ph == PH_GAP));
endmodule

// File: rtl/bitser_tx.sv
module bitser_tx
   import bitser_tx_pkg::*;
#(
   parameter int ADDR_BITS  = 4,
   parameter int BYTE_W     = 8,
   parameter int MAX_BYTES  = 16,
   parameter int PAD_CYCLES = 5,
   parameter int WARMUP     = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(MAX_BYTES)-1:0] wr_idx,
   input  logic [BYTE_W-1:0]            wr_data,
   input  logic                         start,
   input  logic [ADDR_BITS-1:0]         dest,
   input  logic [$clog2(MAX_BYTES)-1:0] len_m1,
   input  logic                         sink_busy_n,
   output logic                         lane_d,
   output logic                         lane_frame_n,
   output logic                         lane_valid_n,
   output logic                         pkt_done
);
   localparam int LEN_W = $clog2(MAX_BYTES);
   localparam int BIT_W = $clog2(BYTE_W);

   generate
      if (ADDR_BITS < 2) begin : g_bad_addr
         $error("bitser_tx: ADDR_BITS must be at least 2");
      end
      if (MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_depth
         $error("bitser_tx: MAX_BYTES must be a power of two >= 2");
      end
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("bitser_tx: BYTE_W must be a power of two >= 2");
      end
      if (PAD_CYCLES < 1) begin : g_bad_pad
         $error("bitser_tx: PAD_CYCLES must be at least 1");
      end
   endgenerate

   phase_e            ph;
   logic              go_ok, addr_bit, last_bit;
   logic [LEN_W-1:0]  rd_idx;
   logic [BIT_W-1:0]  bit_sel;
   logic [BYTE_W-1:0] rd_byte;

   bitser_warmup #(.WARMUP(WARMUP)) u_warm (
      .clk(clk), .rst_n(rst_n), .go_ok(go_ok)
   );

   bitser_buf #(.BYTE_W(BYTE_W), .DEPTH(MAX_BYTES)) u_buf (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_byte(rd_byte)
   );

   bitser_seq #(
      .ADDR_BITS(ADDR_BITS), .BYTE_W(BYTE_W),
      .MAX_BYTES(MAX_BYTES), .PAD_CYCLES(PAD_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .go_ok(go_ok),
      .dest_in(dest), .len_in(len_m1), .sink_busy_n(sink_busy_n),
      .ph(ph), .addr_bit(addr_bit), .rd_idx(rd_idx), .bit_sel(bit_sel),
      .last_bit(last_bit), .done(pkt_done)
   );

   bitser_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ph(ph), .addr_bit(addr_bit),
      .pay_bit(rd_byte[bit_sel]), .last_bit(last_bit),
      .sink_busy_n(sink_busy_n), .lane_d(lane_d),
      .lane_frame_n(lane_frame_n), .lane_valid_n(lane_valid_n)
   );
endmodule

// File: tb/bitser_tx_test.sv
module bitser_tx_test;
   localparam int PADN = 5;
   localparam int WARM = 15;

   logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
   logic       sink_busy_n = 1'b1;
   logic [3:0] wr_idx = '0, dest = '0, len_m1 = '0;
   logic [7:0] wr_data = '0;
   logic       lane_d, lane_frame_n, lane_valid_n, pkt_done;

   int  checks = 0, fails = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   bitser_tx uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .start(start), .dest(dest), .len_m1(len_m1),
      .sink_busy_n(sink_busy_n), .lane_d(lane_d),
      .lane_frame_n(lane_frame_n), .lane_valid_n(lane_valid_n),
      .pkt_done(pkt_done)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] pat(int d, int k);
      return 8'((d * 37 + k * 11 + 5) & 255);
   endfunction

   function automatic bit stalled(int mode, int n);
      case (mode)
         1: return (n % 3) == 1;
         2: return n < 4;
         3: return (n % 5) == 4;
         default: return 1'b0;
      endcase
   endfunction

   task automatic load(int d);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = 4'(k); wr_data = pat(d, k);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_pkt(int d, int lm1, int mode, bit poke);
      int total, p, n;
      logic [3:0] dv;
      logic [7:0] by;
      dv = 4'(d);
      @(negedge clk);
      start = 1'b1; dest = dv; len_m1 = 4'(lm1); sink_busy_n = 1'b1;
      #2;
      chk("R3 idle frame before start", int'(lane_frame_n), 1);
      chk("R8 done back low", int'(pkt_done), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         start = 1'b0; sink_busy_n = dv[0];
         #2;
         chk("R3 address bit", int'(lane_d), int'(dv[i]));
         chk("R3 address frame", int'(lane_frame_n), 0);
         chk("R3 address valid", int'(lane_valid_n), 1);
      end
      for (int i = 0; i < PADN; i++) begin
         @(negedge clk);
         start = poke && (i == 2); dest = ~dv; len_m1 = ~4'(lm1);
         sink_busy_n = dv[1];
         #2;
         chk("R4 pad data", int'(lane_d), 1);
         chk("R4 pad valid", int'(lane_valid_n), 1);
         chk("R4 pad frame", int'(lane_frame_n), 0);
      end
      total = (lm1 + 1) * 8;
      p = 0; n = 0;
      while (p < total) begin
         @(negedge clk);
         start = 1'b0;
         sink_busy_n = !stalled(mode, n);
         n++;
         #2;
         by = pat(d, p / 8);
         if (sink_busy_n) begin
            chk("R5 payload bit (R9 len/dest kept)", int'(lane_d), int'(by[p % 8]));
            chk("R5 payload valid", int'(lane_valid_n), 0);
            chk("R7 frame at accepted bit", int'(lane_frame_n), (p == total - 1) ? 1 : 0);
            p++;
         end else begin
            chk("R6 stall valid", int'(lane_valid_n), 1);
            chk("R6 stall holds bit", int'(lane_d), int'(by[p % 8]));
            chk("R7 frame low while stalled", int'(lane_frame_n), 0);
         end
      end
      @(negedge clk);
      start = poke; sink_busy_n = 1'b1;
      #2;
      chk("R8 gap frame", int'(lane_frame_n), 1);
      chk("R8 gap valid", int'(lane_valid_n), 1);
      chk("R8 gap data", int'(lane_d), 0);
      chk("R8 gap no done", int'(pkt_done), 0);
      @(negedge clk);
      start = 1'b0;
      #2;
      chk("R8 done pulse", int'(pkt_done), 1);
      chk("R9 start in gap ignored", int'(lane_frame_n), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      #2;
      chk("R1 reset frame", int'(lane_frame_n), 1);
      chk("R1 reset valid", int'(lane_valid_n), 1);
      chk("R1 reset data", int'(lane_d), 0);
      chk("R1 reset done", int'(pkt_done), 0);
      start = 1'b0;
      load(3);
      for (int c = 1; c <= WARM; c++) begin
         @(negedge clk);
         rst_n = 1'b1; start = 1'b1; dest = 4'd3;
         #2;
         chk("R2 warm-up start ignored", int'(lane_frame_n), 1);
      end
      run_pkt(3, 1, 0, 1'b0);
      for (int d = 0; d < 16; d++) begin
         load(d);
         run_pkt(d, (d * 7) % 16, d % 4, (d % 3) == 0);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule